// File: doc/BRIEF.md
# Programmable Tick Divider Bank

This block holds six independent frequency generators. Each one takes a tick strobe from one of several rate sources that share the system clock domain, divides the tick rate by a programmed ratio, and produces both a one-cycle output tick strobe and a square-wave toggle output. All six generators are programmed through two 32-bit control words. Each word carries three 10-bit generator fields. Each field packs a divider value, a source choice and an enable.

A build-time parameter picks one of two field encodings. In the legacy encoding, one bit chooses between two sources, a separate bit enables the generator, and the ratio is always even. In the extended encoding, a 2-bit selector chooses one of three sources, and a selector value of zero switches the generator off. A scale bit in each control word also lets that word's generators divide by any integer.

Each generator is a two-state machine. In ST_OFF the outputs are low and the counter is clear. ST_OFF moves to ST_COUNT when the field becomes enabled, and that transition latches the source and the ratio. ST_COUNT wraps onto itself when it completes a period, and it latches the new configuration at that point. ST_COUNT returns to ST_OFF as soon as the field is disabled.

Top module: `fgen_bank`

## Requirements
- R1: Generator k is programmed by control word k/3 (integer division), in bits [10*(k%3)+9 : 10*(k%3)]. Within a field, bits [9:2] hold the divider value N.
- R2: In the legacy encoding, field bit 1 enables the generator. Field bit 0 chooses the source: 0 selects the CPU-rate tick and 1 selects the auxiliary tick. The ratio is (N+1)*2, which gives 2 to 512.
- R3: In the extended encoding, field bits [1:0] choose the source. Code 1 selects the secondary auxiliary tick, code 2 the CPU-rate tick and code 3 the auxiliary tick. Code 0 means the generator is off.
- R4: In the extended encoding, bit 30 of each control word is a scale bit for that word's three generators. When the bit is set the ratio is N+1 (1 to 256). When it is clear the ratio is (N+1)*2. In the legacy encoding bit 30 has no effect.
- R5: Reading a control word returns the value last written to it, with unused bits reading as zero. Bit 31 is always zero, and bit 30 is also zero in the legacy encoding.
- R6: A running generator counts ticks from its selected source. On the edge that registers the R-th tick (R is the ratio), the generator raises gen_tick for one cycle and inverts gen_clk.
- R7: A change to the divider value or the source of a running generator takes effect only at its next period boundary. The period in progress finishes with the old ratio.
- R8: A disabled generator holds gen_clk and gen_tick low and clears its count. After it is enabled again, its first gen_tick is registered exactly R counted ticks later. Counting starts one cycle after the enable is written.
- R9: With a ratio of 1, every selected source tick produces a gen_tick, and gen_clk changes on each of them.
- R10: After reset, both control words read as zero and every generator output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for a control word |
| wr_sel | input | 1 | Index of the control word to write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Index of the control word to read |
| rd_data | output | 32 | Read data (combinational) |
| src_cpu_tick | input | 1 | CPU-rate source tick strobe |
| src_aux_tick | input | 1 | Auxiliary source tick strobe |
| src_aux2_tick | input | 1 | Secondary auxiliary source tick strobe |
| gen_clk | output | 6 | Toggle output for each generator |
| gen_tick | output | 6 | One-cycle output tick for each generator |

## Verification
The bench measures output tick intervals while the three sources run at different fixed rates. A wrong source decode, a missing doubling, or a scale bit that is ignored therefore shows up as an interval off by a known factor. This covers the top ratio of 512 and the direct ratio of 1; a design that drops the ninth ratio bit would wrap at 512, and one that mishandles ratio 1 would never fire. The bench changes the divider value in the middle of a period: a design that applies the change at once would cut that period short. It also disables and re-enables a generator partway through a period: a design that keeps the old count would fire early. Finally, it writes all-ones to the control words and expects the unused bits to read back as zero, which exposes a register that keeps them.

// File: rtl/fgen_pkg.sv
package fgen_pkg;

    localparam int FIELD_W = 10;
    localparam int DIV_W   = 8;
    localparam int RATIO_W = DIV_W + 2;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_CPU  = 2'd1,
        SRC_AUX  = 2'd2,
        SRC_AUX2 = 2'd3
    } src_e;

    typedef struct packed {
        logic               on;
        src_e               src;
        logic [RATIO_W-1:0] ratio;
    } gen_cfg_t;

    // Turn one control field into an enable, a source and a divide ratio.
    function automatic gen_cfg_t decode_field(input logic [FIELD_W-1:0] f,
                                              input logic               scale,
                                              input logic               ext);
        gen_cfg_t           c;
        logic [RATIO_W-1:0] base;
        base = RATIO_W'(f[FIELD_W-1:2]) + RATIO_W'(1);
        if (ext) begin
            c.on = (f[1:0] != 2'd0);
            unique case (f[1:0])
                2'd1:    c.src = SRC_AUX2;
                2'd2:    c.src = SRC_CPU;
                2'd3:    c.src = SRC_AUX;
                default: c.src = SRC_NONE;
            endcase
            c.ratio = scale ? base : (base << 1);
        end else begin
            c.on    = f[1];
            c.src   = f[0] ? SRC_AUX : SRC_CPU;
            c.ratio = base << 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/fgen_regs.sv
module fgen_regs
    import fgen_pkg::*;
#(
    parameter int NUM_GEN     = 6,
    parameter int GEN_PER_REG = 3,
    parameter int SCALE_BIT   = 30,
    parameter bit EXTENDED    = 1'b1,
    localparam int NUM_REG    = (NUM_GEN + GEN_PER_REG - 1) / GEN_PER_REG,
    localparam int SEL_W      = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [SEL_W-1:0]              wr_sel,
    input  logic [31:0]                   wr_data,
    input  logic [SEL_W-1:0]              rd_sel,
    output logic [31:0]                   rd_data,
    output logic [NUM_GEN-1:0][FIELD_W-1:0] fields,
    output logic [NUM_GEN-1:0]            scales
);

    localparam int USED_W = EXTENDED ? (SCALE_BIT + 1) : (GEN_PER_REG * FIELD_W);
    localparam logic [31:0] KEEP = (USED_W >= 32) ? '1 : ((32'd1 << USED_W) - 32'd1);

    logic [31:0] ctl [NUM_REG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REG; r++) ctl[r] <= '0;
        end else if (wr_en) begin
            ctl[wr_sel] <= wr_data & KEEP;
        end
    end

    assign rd_data = ctl[rd_sel];

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_field
        localparam int REG = g / GEN_PER_REG;
        localparam int LSB = FIELD_W * (g % GEN_PER_REG);
        assign fields[g] = ctl[REG][LSB +: FIELD_W];
        if (EXTENDED) begin : g_scale
            assign scales[g] = ctl[REG][SCALE_BIT];
        end else begin : g_noscale
            assign scales[g] = 1'b0;
        end
    end

endmodule

// File: rtl/fgen_divider.sv
module fgen_divider
    import fgen_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  gen_cfg_t cfg,
    input  logic     src_cpu_tick,
    input  logic     src_aux_tick,
    input  logic     src_aux2_tick,
    output logic     gen_clk,
    output logic     gen_tick
);

    typedef enum logic {ST_OFF, ST_COUNT} state_e;

    state_e             state, state_nx;
    src_e               act_src;
    logic [RATIO_W-1:0] act_ratio;
    logic [RATIO_W-1:0] cnt;
    logic               src_hit;
    logic               period_end;

    always_comb begin
        unique case (act_src)
            SRC_CPU:  src_hit = src_cpu_tick;
            SRC_AUX:  src_hit = src_aux_tick;
            SRC_AUX2: src_hit = src_aux2_tick;
            default:  src_hit = 1'b0;
        endcase
    end

    assign period_end = src_hit && (cnt == act_ratio - RATIO_W'(1));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:   if (cfg.on)  state_nx = ST_COUNT;
            ST_COUNT: if (!cfg.on) state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            act_src   <= SRC_NONE;
            act_ratio <= RATIO_W'(2);
            gen_clk   <= 1'b0;
            gen_tick  <= 1'b0;
        end else begin
            gen_tick <= 1'b0;
            unique case (state)
                ST_OFF: begin
                    gen_clk <= 1'b0;
                    cnt     <= '0;
                    if (cfg.on) begin
                        act_src   <= cfg.src;
                        act_ratio <= cfg.ratio;
                    end
                end
                ST_COUNT: begin
                    if (!cfg.on) begin
                        gen_clk <= 1'b0;
                        cnt     <= '0;
                    end else if (period_end) begin
                        cnt       <= '0;
                        gen_tick  <= 1'b1;
                        gen_clk   <= ~gen_clk;
                        act_src   <= cfg.src;
                        act_ratio <= cfg.ratio;
                    end else if (src_hit) begin
                        cnt <= cnt + RATIO_W'(1);
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/fgen_bank.sv
module fgen_bank
    import fgen_pkg::*;
#(
    parameter int NUM_GEN     = 6,
    parameter int GEN_PER_REG = 3,
    parameter int SCALE_BIT   = 30,
    parameter bit EXTENDED    = 1'b1,
    localparam int NUM_REG    = (NUM_GEN + GEN_PER_REG - 1) / GEN_PER_REG,
    localparam int SEL_W      = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [31:0]        wr_data,
    input  logic [SEL_W-1:0]   rd_sel,
    output logic [31:0]        rd_data,
    input  logic               src_cpu_tick,
    input  logic               src_aux_tick,
    input  logic               src_aux2_tick,
    output logic [NUM_GEN-1:0] gen_clk,
    output logic [NUM_GEN-1:0] gen_tick
);

    logic [NUM_GEN-1:0][FIELD_W-1:0] fields;
    logic [NUM_GEN-1:0]              scales;
    logic [NUM_GEN-1:0]              gen_on;

    fgen_regs #(
        .NUM_GEN    (NUM_GEN),
        .GEN_PER_REG(GEN_PER_REG),
        .SCALE_BIT  (SCALE_BIT),
        .EXTENDED   (EXTENDED)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .wr_data(wr_data),
        .rd_sel (rd_sel),
        .rd_data(rd_data),
        .fields (fields),
        .scales (scales)
    );

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        gen_cfg_t cfg;
        assign cfg       = decode_field(fields[g], scales[g], EXTENDED);
        assign gen_on[g] = cfg.on;

        fgen_divider u_div (
            .clk          (clk),
            .rst_n        (rst_n),
            .cfg          (cfg),
            .src_cpu_tick (src_cpu_tick),
            .src_aux_tick (src_aux_tick),
            .src_aux2_tick(src_aux2_tick),
            .gen_clk      (gen_clk[g]),
            .gen_tick     (gen_tick[g])
        );
    end

endmodule

// File: rtl/fgen_bank_chk.sv
module fgen_bank_chk #(
    parameter int NUM_GEN  = 6,
    parameter bit EXTENDED = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [31:0]        rd_data,
    input logic [NUM_GEN-1:0] gen_on,
    input logic [NUM_GEN-1:0] gen_clk,
    input logic [NUM_GEN-1:0] gen_tick
);

    // R5: top bit never reads back
    a_r5_bit31_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[31] == 1'b0);

    if (!EXTENDED) begin : g_leg
        // R4/R5: scale position is unused in the legacy encoding
        a_r4_legacy_noscale: assert property (@(posedge clk) disable iff (!rst_n)
            rd_data[30] == 1'b0);
    end

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
        // R8: a disabled generator drives nothing on the following cycle
        a_r8_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !gen_on[g] |=> (!gen_clk[g] && !gen_tick[g]));
        // R6: toggle output only rises together with an output tick
        a_r6_rise_with_tick: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gen_clk[g]) |-> gen_tick[g]);
        // R6: every output tick inverts the toggle output
        a_r6_tick_toggles: assert property (@(posedge clk) disable iff (!rst_n)
            gen_tick[g] |-> (gen_clk[g] != $past(gen_clk[g])));
        // R8: ticks come only from a generator that was enabled
        a_r8_tick_needs_on: assert property (@(posedge clk) disable iff (!rst_n)
            gen_tick[g] |-> $past(gen_on[g]));
    end

endmodule

bind fgen_bank fgen_bank_chk #(
    .NUM_GEN (NUM_GEN),
    .EXTENDED(EXTENDED)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_data (rd_data),
    .gen_on  (gen_on),
    .gen_clk (gen_clk),
    .gen_tick(gen_tick)
);

// File: tb/fgen_bank_tb.sv
`timescale 1ns/1ps
module fgen_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en_x = 1'b0, wr_en_l = 1'b0;
    logic        wr_sel = 1'b0, rd_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_x, rd_l;
    logic        s_cpu = 1'b0, s_aux = 1'b0, s_aux2 = 1'b0;
    logic [5:0]  clk_x, tick_x, clk_l, tick_l;
    int          cyc = 0, n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fgen_bank #(.EXTENDED(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_x), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_x),
        .src_cpu_tick(s_cpu), .src_aux_tick(s_aux), .src_aux2_tick(s_aux2),
        .gen_clk(clk_x), .gen_tick(tick_x));

    fgen_bank #(.EXTENDED(1'b0)) u_leg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_l), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_l),
        .src_cpu_tick(s_cpu), .src_aux_tick(s_aux), .src_aux2_tick(s_aux2),
        .gen_clk(clk_l), .gen_tick(tick_l));

    // Sources: CPU-rate every cycle, auxiliary every 2nd, secondary every 3rd.
    initial forever begin
        @(negedge clk);
        s_cpu  = 1'b1;
        s_aux  = (cyc % 2) == 0;
        s_aux2 = (cyc % 3) == 0;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Caller is at a negedge; returns at the negedge after the write edge.
    task automatic wr(input bit leg, input bit sel, input logic [31:0] d);
        wr_sel = sel; wr_data = d;
        if (leg) wr_en_l = 1'b1; else wr_en_x = 1'b1;
        @(negedge clk);
        wr_en_l = 1'b0; wr_en_x = 1'b0;
    endtask

    task automatic wait_tick(input bit leg, input int g, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(leg ? tick_l[g] : tick_x[g]) && n < 5000);
    endtask

    task automatic measure(input bit leg, input int g, output int n);
        int d;
        wait_tick(leg, g, d);
        wait_tick(leg, g, d);
        wait_tick(leg, g, n);
    endtask

    typedef struct packed {
        logic [2:0]  gen;
        logic        scale;
        logic [9:0]  field;
        logic [15:0] expect_iv;
    } vec_t;

    // field = {N, select}; interval = ratio * source period
    localparam vec_t VECS [7] = '{
        '{3'd0, 1'b0, {8'd0,   2'd2}, 16'd2},
        '{3'd1, 1'b0, {8'd2,   2'd3}, 16'd12},
        '{3'd2, 1'b1, {8'd1,   2'd1}, 16'd6},
        '{3'd3, 1'b1, {8'd4,   2'd2}, 16'd5},
        '{3'd5, 1'b1, {8'd0,   2'd3}, 16'd2},
        '{3'd4, 1'b0, {8'd255, 2'd2}, 16'd512},
        '{3'd4, 1'b1, {8'd255, 2'd2}, 16'd256}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<%0d cycles", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n, c1, c2, cnt;
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        for (int r = 0; r < 2; r++) begin
            rd_sel = r[0]; #1;
            check(rd_x == 0 && rd_l == 0, "R10 reset readback", rd_x | rd_l, 0);
        end
        check(clk_x == 0 && tick_x == 0 && clk_l == 0 && tick_l == 0,
              "R10 reset outputs", {clk_x, tick_x, clk_l, tick_l}, 0);

        // R1 R3 R4 R5 R6: vector table on the extended build
        for (int i = 0; i < 7; i++) begin
            int g = int'(VECS[i].gen);
            v = (32'(VECS[i].field) << (10 * (g % 3))) | (32'(VECS[i].scale) << 30);
            wr(1'b0, (g / 3) != 0, v);
            rd_sel = (g / 3) != 0; #1;
            check(rd_x == v, $sformatf("R5 readback vec%0d", i), rd_x, v);
            measure(1'b0, g, n);
            check(n == int'(VECS[i].expect_iv),
                  $sformatf("R1 R3 R4 R6 interval vec%0d", i), n, VECS[i].expect_iv);
        end

        // R5: unused bits read zero
        wr(1'b0, 1'b1, 32'hFFFF_FFFF);
        rd_sel = 1'b1; #1;
        check(rd_x == 32'h7FFF_FFFF, "R5 ext unused bits", rd_x, 32'h7FFF_FFFF);
        wr(1'b1, 1'b0, 32'hFFFF_FFFF);
        rd_sel = 1'b0; #1;
        check(rd_l == 32'h3FFF_FFFF, "R5 legacy unused bits", rd_l, 32'h3FFF_FFFF);
        wr(1'b0, 1'b1, 32'h0);

        // R2: legacy gen1, N=3, enabled, auxiliary -> ratio 8 * 2
        wr(1'b1, 1'b0, 32'((3 << 2) | 3) << 10);
        measure(1'b1, 1, n);
        check(n == 16, "R2 legacy aux ratio", n, 16);
        // R2 R4: legacy gen3 CPU N=1 with bit 30 set -> still ratio 4
        wr(1'b1, 1'b1, (32'd1 << 30) | 32'((1 << 2) | 2));
        measure(1'b1, 3, n);
        check(n == 4, "R4 legacy scale ignored", n, 4);

        // R8: legacy generator with enable clear but source bit set stays quiet
        wr(1'b1, 1'b0, 32'((3 << 2) | 1) << 10);
        cnt = 0;
        repeat (100) begin
            @(negedge clk);
            if (tick_l[1] || clk_l[1]) cnt++;
        end
        check(cnt == 0, "R8 legacy disabled quiet", cnt, 0);

        // R9: ratio 1 on CPU source -> tick and toggle every cycle
        wr(1'b0, 1'b0, (32'd1 << 30) | (32'((0 << 2) | 2) << 20));
        wait_tick(1'b0, 2, n);
        c1 = clk_x[2];
        wait_tick(1'b0, 2, n);
        c2 = clk_x[2];
        check(n == 1 && c1 != c2, "R9 ratio one passthrough", {n[7:0], 4'(c1), 4'(c2)}, 16'h0110);

        // R7: change N mid-period; current period of 8 completes first
        wr(1'b0, 1'b0, 32'((3 << 2) | 2));
        measure(1'b0, 0, n);
        wr(1'b0, 1'b0, 32'((0 << 2) | 2));
        wait_tick(1'b0, 0, n);
        // one cycle of the 8-tick period was spent in the write
        check(n == 7, "R7 old period finishes", n, 7);
        wait_tick(1'b0, 0, n);
        check(n == 2, "R7 new ratio applies", n, 2);

        // R8: disable mid-period, then re-enable -> full fresh period
        wr(1'b0, 1'b0, 32'((1 << 2) | 2));
        measure(1'b0, 0, n);
        @(negedge clk);
        @(negedge clk);
        wr(1'b0, 1'b0, 32'h0);
        @(negedge clk);
        check(clk_x[0] == 1'b0, "R8 disabled output low", clk_x[0], 0);
        cnt = 0;
        repeat (40) begin
            @(negedge clk);
            if (tick_x[0]) cnt++;
        end
        check(cnt == 0, "R8 ext disabled no ticks", cnt, 0);
        wr(1'b0, 1'b0, 32'((1 << 2) | 2));
        wait_tick(1'b0, 0, n);
        check(n == 5, "R8 first tick after enable", n, 5);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule